// File: doc/BRIEF.md
# Edge-Aligned Pulse Burst Gate

This block passes a burst of whole pulses from a free-running pulse stream for as long as a gate input is held, and it never cuts a pulse short. The pulse stream and the gate come from sources that are not synchronized to each other. Both are oversampled by a fast system clock. The gate is turned into an enable that changes only on a falling edge of the sampled pulse stream. The output is the registered AND of the sampled stream and that enable. Because the enable can only move while the stream is low, every pulse the block sends out has the same width as the input pulse.

A gate held across N falling edges of the stream lets N pulses through: the pulse after each of those falling edges. When a gate edge lands on a pulse edge, the sampling point decides whether that pulse is in or out, so the count may be one off, but the pulse is never partial. A saturating counter reports how many pulses the current burst has passed. It restarts from zero at each new gate assertion.

Top module: `pulse_burst_gate`

## Requirements
- R1: While the enable is set, the output follows the pulse input with a fixed latency of three clock cycles (two synchronizer stages plus the output register), and the output is never high unless the synchronized pulse was high.
- R2: The internal enable takes the synchronized gate value only in the cycle after a falling edge of the synchronized pulse is detected, and it never changes at any other time.
- R3: With the gate changes kept clear of pulse edges, a gate held high across N falling edges of the pulse input produces exactly N output pulses.
- R4: Every output pulse is exactly as wide, in clock cycles, as the input pulse it copies, including when the gate rises or falls while a pulse is high.
- R5: While the gate stays low, the output stays low and the pass counter keeps its value.
- R6: The pass counter increases by one in the same cycle that the output rises.
- R7: A rising edge of the synchronized gate sets the pass counter to zero, and this takes precedence over an increment.
- R8: The pass counter saturates at its all-ones value (255 with the default 8-bit width) and does not wrap.
- R9: An active-low reset input asynchronously clears the output, the pass counter and the enable. Release of the reset is synchronized to the clock.
- R10: Input high times from one clock cycle up to one cycle less than the period are passed whole, including a low time of a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Free-running pulse stream, asynchronous |
| gate_in | input | 1 | Burst request, asynchronous, high = pass pulses |
| burst_out | output | 1 | Registered gated pulse stream |
| pass_count | output | CNT_W | Saturating count of pulses passed in the current burst |

## Verification
The hardest situation to reach is a gate edge that arrives while a pulse is high. If the enable moved at that moment, the output would be truncated, and the bug could look like a correct pulse count. The stimulus steps the gate on and off in the middle of input pulses. It also uses a one-cycle pulse and a one-cycle low gap, so that the falling-edge update has no slack. The bench measures the width of every output pulse against the input high time. Saturation is reached by running a 300-pulse burst with a short period.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  localparam int unsigned DEF_CNT_W       = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/pbg_sync.sv
module pbg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pbg_edge.sv
module pbg_edge (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sig,
  output pbg_pkg::edge_t ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  always_comb begin
    ev.rise = sig & ~prev_q;
    ev.fall = ~sig & prev_q;
  end
endmodule

// File: rtl/pbg_gate_ctrl.sv
module pbg_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_s,
  input  logic gate_s,
  input  logic pulse_fall,
  output logic en_o,
  output logic out_o,
  output logic out_rise_o
);
  logic en_q, en_d;
  logic out_q, out_d;

  always_comb begin
    en_d = en_q;
    if (pulse_fall) en_d = gate_s;
    out_d      = pulse_s & en_q;
    out_rise_o = out_d & ~out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign en_o  = en_q;
  assign out_o = out_q;
endmodule

// File: rtl/pbg_counter.sv
module pbg_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != CNT_MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pulse_burst_gate.sv
module pulse_burst_gate #(
  parameter int unsigned CNT_W       = pbg_pkg::DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = pbg_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             gate_in,
  output logic             burst_out,
  output logic [CNT_W-1:0] pass_count
);
  logic           rst_n_sync;
  logic           pulse_s, gate_s;
  pbg_pkg::edge_t pulse_ev, gate_ev;
  logic           pulse_fall, pulse_rise, gate_rise;
  logic           gate_en, out_rise;

  pbg_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_sync)
  );

  pbg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n_sync), .d({gate_in, pulse_in}), .q({gate_s, pulse_s})
  );

  pbg_edge u_pulse_edge (.clk(clk), .rst_n(rst_n_sync), .sig(pulse_s), .ev(pulse_ev));
  pbg_edge u_gate_edge  (.clk(clk), .rst_n(rst_n_sync), .sig(gate_s),  .ev(gate_ev));

  assign pulse_fall = pulse_ev.fall;
  assign pulse_rise = pulse_ev.rise;
  assign gate_rise  = gate_ev.rise;

  pbg_gate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_sync), .pulse_s(pulse_s), .gate_s(gate_s),
    .pulse_fall(pulse_fall), .en_o(gate_en), .out_o(burst_out), .out_rise_o(out_rise)
  );

  pbg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .inc(out_rise), .clr(gate_rise), .count(pass_count)
  );
endmodule

// File: rtl/pbg_checker.sv
module pbg_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_out,
  input logic [CNT_W-1:0] pass_count,
  input logic             pulse_s,
  input logic             gate_en,
  input logic             pulse_fall,
  input logic             pulse_rise,
  input logic             gate_rise
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_out_needs_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    burst_out |-> $past(pulse_s));

  p_en_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_en) |-> $past(pulse_fall));

  p_whole_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_out) |-> $past(pulse_rise));

  p_whole_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_out) |-> $past(pulse_fall));

  p_step_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pass_count) != CNT_MAX && pass_count == $past(pass_count) + 1'b1)
      |-> $rose(burst_out));

  p_only_step_or_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_count != $past(pass_count))
      |-> (pass_count == $past(pass_count) + 1'b1 && $past(pass_count) != CNT_MAX)
          || pass_count == '0);

  p_clear_on_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> pass_count == '0);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pass_count) == CNT_MAX && pass_count != CNT_MAX) |-> pass_count == '0);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r9: assert (!burst_out && pass_count == '0 && !gate_en);
    end
  end
endmodule

bind pulse_burst_gate pbg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_out(burst_out), .pass_count(pass_count),
  .pulse_s(pulse_s), .gate_en(gate_en), .pulse_fall(pulse_fall),
  .pulse_rise(pulse_rise), .gate_rise(gate_rise)
);

// File: tb/tb_pulse_burst_gate.sv
module tb_pulse_burst_gate;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_in = 1'b0;
  logic             gate_in = 1'b0;
  logic             burst_out;
  logic [CNT_W-1:0] pass_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mon_rises = 0;
  int mon_bad = 0;
  int mon_w = 0;
  int exp_h = 0;
  logic mon_prev = 1'b0;

  pulse_burst_gate #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_in(gate_in),
    .burst_out(burst_out), .pass_count(pass_count)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (burst_out && !mon_prev) begin
      mon_rises = mon_rises + 1;
      mon_w = 1;
    end else if (burst_out) begin
      mon_w = mon_w + 1;
    end else if (mon_prev && mon_w != exp_h) begin
      mon_bad = mon_bad + 1;
      $display("width mismatch: got %0d cycles, want %0d", mon_w, exp_h);
    end
    mon_prev = burst_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic mon_clear(input int h);
    mon_rises = 0;
    mon_bad = 0;
    exp_h = h;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulse_in = 1'b0;
      gate_in = 1'b0;
    end
  endtask

  task automatic drive(input int p, input int h, input int gs, input int ge, input int cyc);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      pulse_in = ((c % p) < h);
      gate_in = (c >= gs && c < ge);
    end
    idle(8);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(4);
    check(burst_out == 1'b0, "R9 out in reset", int'(burst_out), 0);
    check(pass_count == 0, "R9 count in reset", int'(pass_count), 0);
    rst_n = 1'b1;
    idle(5);
  endtask

  task automatic t_gate_low;
    mon_clear(5);
    drive(20, 5, 1000, 1000, 200);
    check(mon_rises == 0, "R5 pulses with gate low", mon_rises, 0);
    check(pass_count == 0, "R5 count with gate low", int'(pass_count), 0);
  endtask

  task automatic t_clean_burst;
    mon_clear(5);
    drive(20, 5, 30, 90, 240);
    check(mon_rises == 3, "R3 burst of three", mon_rises, 3);
    check(mon_bad == 0, "R4 widths in clean burst", mon_bad, 0);
    check(pass_count == 3, "R6 count after burst", int'(pass_count), 3);
  endtask

  task automatic t_mid_pulse_edges;
    mon_clear(5);
    for (int c = 0; c < 240; c++) begin
      @(negedge clk);
      if (c == 46) check(pass_count == 0, "R7 clear on gate rise", int'(pass_count), 0);
      pulse_in = ((c % 20) < 5);
      gate_in = (c >= 42 && c < 102);
    end
    idle(8);
    check(mon_rises == 3, "R3 burst with edges in pulses", mon_rises, 3);
    check(mon_bad == 0, "R4 no runt with edges in pulses", mon_bad, 0);
    check(pass_count == 3, "R6 count second burst", int'(pass_count), 3);
  endtask

  task automatic t_latency;
    int first_hi;
    first_hi = -1;
    mon_clear(5);
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (first_hi < 0 && burst_out) first_hi = c;
      pulse_in = ((c % 20) < 5);
      gate_in = (c >= 10 && c < 50);
    end
    idle(8);
    check(first_hi == 43, "R1 output latency", first_hi, 43);
    check(mon_rises == 2, "R2 enable waits for fall", mon_rises, 2);
  endtask

  task automatic t_narrow_low;
    mon_clear(5);
    drive(6, 5, 8, 26, 60);
    check(mon_rises == 3, "R10 one-cycle low count", mon_rises, 3);
    check(mon_bad == 0, "R10 one-cycle low widths", mon_bad, 0);
  endtask

  task automatic t_narrow_high;
    mon_clear(1);
    drive(10, 1, 5, 35, 80);
    check(mon_rises == 3, "R10 one-cycle high count", mon_rises, 3);
    check(mon_bad == 0, "R10 one-cycle high widths", mon_bad, 0);
  endtask

  task automatic t_saturate;
    mon_clear(2);
    drive(4, 2, 1, 1201, 1230);
    check(mon_rises == 300, "R3 long burst count", mon_rises, 300);
    check(pass_count == 255, "R8 counter saturates", int'(pass_count), 255);
  endtask

  task automatic t_reset_mid;
    mon_clear(5);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (c == 25) begin
        check(burst_out == 1'b1 && pass_count == 1, "R9 pre-reset burst", int'(pass_count), 1);
        rst_n = 1'b0;
        #1;
        check(burst_out == 1'b0, "R9 async clear out", int'(burst_out), 0);
        check(pass_count == 0, "R9 async clear count", int'(pass_count), 0);
      end
      pulse_in = ((c % 20) < 5);
      gate_in = 1'b1;
    end
    rst_n = 1'b1;
    idle(10);
  endtask

  initial begin
    t_reset();
    t_gate_low();
    t_clean_burst();
    t_mid_pulse_edges();
    t_latency();
    t_narrow_low();
    t_narrow_high();
    t_saturate();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule